// File: doc/BRIEF.md
# Dual-Mapped Peripheral Register Space

This block is the peripheral register space of a small CPU. It has 64 byte-wide locations that the core reaches in two ways. I/O instructions use a 6-bit port index. Data-memory loads and stores reach the same storage through a window that starts at 0x20, so data address A selects port index A−0x20. Bit instructions (set, clear, test) are a third access path. They are legal only in the lower 32 port locations. A set or clear is done as a read-modify-write of the whole byte.

The block holds four sample registers:
- a read/write control byte at port 0x05;
- a status byte at port 0x06, whose flags are raised by hardware and cleared by writing a one;
- a read-only input byte at port 0x07 that mirrors a pin bus;
- a read/write scratch byte at port 0x2A, which is outside the bit-access range.

Every other location is reserved: it reads as zero and ignores writes.

Reads are combinational from the address. Writes take effect on the rising clock edge. At most one write is committed per cycle.

Top module: `periph_io_space`

## Requirements
- R1: `io_rdata_o` shows, combinationally, the register at `io_addr_i`. A reserved location reads 0x00, and a write to it leaves its read value at 0x00.
- R2: A data address in 0x20..0x5F sets `dm_hit_o` and accesses port index (address − 0x20). Any data address outside that window, including one whose low bits alias a register, clears `dm_hit_o`, returns 0x00 on `dm_rdata_o` and changes no register.
- R3: The control register at port 0x05 (data address 0x25) is read/write, holds all 8 bits, and takes a written value at the next rising edge.
- R4: Status bits 3:0 at port 0x06 are set by `flag_set_i`. A written 1 clears a flag and a written 0 leaves it unchanged. Bits 7:4 always read 0, and `flag_set_i[7:4]` has no effect.
- R5: If the hardware sets a status flag in the same cycle that a write clears it, the flag stays set.
- R6: Port 0x07 reads `ext_in_i` live. Writes to it are ignored.
- R7: `bit_op_i` encodes 01 = set, 10 = clear, 11 = test, 00 = none. A set or clear at a port index below 0x20 changes only bit `bit_sel_i` of the control register, at the next edge.
- R8: A bit set or clear on the status register writes back the whole byte as read. Every flag read as 1 is therefore cleared: a set also clears the target bit, and a clear clears every set flag except the target bit.
- R9: `bit_val_o` shows bit `bit_sel_i` of the register at `bit_addr_i` for any legal bit request. A test writes nothing.
- R10: A bit request at port index 0x20 or above drives `illegal_o` high and `bit_val_o` low, and leaves every register unchanged.
- R11: The scratch register at port 0x2A (data address 0x4A) is read/write through the port path and the data path.
- R12: When several writes arrive in one cycle, only one is committed. The port write wins over a bit set or clear, and a bit set or clear wins over a data write.
- R13: After reset, the control, status and scratch registers read 0x00 and `illegal_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_we_i | input | 1 | Port-path write strobe |
| io_addr_i | input | 6 | Port index |
| io_wdata_i | input | 8 | Port-path write data |
| io_rdata_o | output | 8 | Port-path read data |
| bit_op_i | input | 2 | Bit operation: 00 none, 01 set, 10 clear, 11 test |
| bit_addr_i | input | 6 | Port index of the bit operation |
| bit_sel_i | input | 3 | Bit position within the byte |
| bit_val_o | output | 1 | Selected bit value |
| illegal_o | output | 1 | Bit request outside the lower 32 locations |
| dm_we_i | input | 1 | Data-path write strobe |
| dm_addr_i | input | 16 | Data address |
| dm_wdata_i | input | 8 | Data-path write data |
| dm_rdata_o | output | 8 | Data-path read data |
| dm_hit_o | output | 1 | Data address falls in the register window |
| flag_set_i | input | 8 | Hardware set pulses for the status flags |
| ext_in_i | input | 8 | Pin bus mirrored by the input register |
| ctrl_o | output | 8 | Current control register value |

## Verification
Two kinds of collision can fall in one cycle.

The first is a hardware flag set that coincides with a write-one-to-clear on the same status bit. The bench provokes it by pulsing `flag_set_i` in the same cycle as a port write of 1, then reads the flag back after the edge and expects it still set.

The second is a port write, a bit set and a data write that all target the control register at once. The bench drives all three in the same cycle, then drops the strongest and repeats. After each edge the control value must equal the write that has priority.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam int unsigned AW       = 6;
  localparam int unsigned DW       = 8;
  localparam int unsigned SPAN     = 1 << AW;
  localparam int unsigned BIT_SPAN = SPAN / 2;
  localparam int unsigned DM_BASE  = 32;

  typedef enum logic [1:0] {
    BOP_NONE = 2'b00,
    BOP_SET  = 2'b01,
    BOP_CLR  = 2'b10,
    BOP_TST  = 2'b11
  } bit_op_e;
endpackage

// File: rtl/prs_addr_map.sv
module prs_addr_map
  import prs_pkg::*;
#(
  parameter int unsigned DM_AW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DM_AW-1:0] dm_addr_i,
  input  logic             dm_we_i,
  output logic             dm_hit_o,
  output logic [AW-1:0]    dm_idx_o,
  output logic             dm_wr_o,
  input  logic [AW-1:0]    bit_addr_i,
  output logic             bit_ok_o
);
  localparam logic [DM_AW-1:0] LO = DM_AW'(DM_BASE);
  localparam logic [DM_AW-1:0] HI = DM_AW'(DM_BASE + SPAN);

  logic [DM_AW-1:0] off;

  assign off      = dm_addr_i - LO;
  assign dm_hit_o = (dm_addr_i >= LO) && (dm_addr_i < HI);
  assign dm_idx_o = off[AW-1:0];
  assign dm_wr_o  = dm_we_i && dm_hit_o;
  assign bit_ok_o = bit_addr_i < AW'(BIT_SPAN);

  // a data write outside the window must never reach the register file
  assert_dm_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dm_addr_i < LO || dm_addr_i >= HI) |-> !dm_wr_o);
endmodule

// File: rtl/prs_bit_rmw.sv
module prs_bit_rmw
  import prs_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    op_i,
  input  logic [2:0]    sel_i,
  input  logic          addr_ok_i,
  input  logic [DW-1:0] rd_i,
  output logic          wr_o,
  output logic [DW-1:0] wdata_o,
  output logic          val_o,
  output logic          illegal_o
);
  bit_op_e       op;
  logic [DW-1:0] mask;
  logic          req;

  assign op   = bit_op_e'(op_i);
  assign mask = DW'(1) << sel_i;
  assign req  = op != BOP_NONE;

  assign illegal_o = req && !addr_ok_i;
  assign val_o     = req && addr_ok_i && rd_i[sel_i];

  always_comb begin
    wr_o    = 1'b0;
    wdata_o = rd_i;
    if (req && addr_ok_i) begin
      unique case (op)
        BOP_SET: begin wr_o = 1'b1; wdata_o = rd_i | mask;  end
        BOP_CLR: begin wr_o = 1'b1; wdata_o = rd_i & ~mask; end
        default: ;
      endcase
    end
  end

  assert_illegal_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wr_o);
  assert_test_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b11) |-> !wr_o);
endmodule

// File: rtl/prs_regs.sv
module prs_regs
  import prs_pkg::*;
#(
  parameter int unsigned   NRD       = 3,
  parameter logic [AW-1:0] CTRL_IDX  = 6'h05,
  parameter logic [AW-1:0] STAT_IDX  = 6'h06,
  parameter logic [AW-1:0] IN_IDX    = 6'h07,
  parameter logic [AW-1:0] SCR_IDX   = 6'h2A,
  parameter logic [DW-1:0] STAT_MASK = 8'h0F
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [AW-1:0]           wr_idx_i,
  input  logic [DW-1:0]           wr_data_i,
  input  logic [DW-1:0]           flag_set_i,
  input  logic [DW-1:0]           ext_in_i,
  input  logic [NRD-1:0][AW-1:0]  rd_idx_i,
  output logic [NRD-1:0][DW-1:0]  rd_data_o,
  output logic [DW-1:0]           ctrl_o
);
  logic [DW-1:0] ctrl_q, stat_q, scr_q, stat_set, stat_clr;

  function automatic logic [DW-1:0] rd_mux(input logic [AW-1:0] idx,
      input logic [DW-1:0] c, input logic [DW-1:0] s,
      input logic [DW-1:0] x, input logic [DW-1:0] p);
    logic [DW-1:0] r;
    r = '0;
    if (idx == CTRL_IDX) r = c;
    if (idx == STAT_IDX) r = s;
    if (idx == IN_IDX)   r = p;
    if (idx == SCR_IDX)  r = x;
    return r;
  endfunction

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data_o[g] = rd_mux(rd_idx_i[g], ctrl_q, stat_q, scr_q, ext_in_i);
  end

  assign stat_set = flag_set_i & STAT_MASK;
  assign stat_clr = (wr_en_i && wr_idx_i == STAT_IDX) ? (wr_data_i & STAT_MASK) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      stat_q <= '0;
      scr_q  <= '0;
    end else begin
      if (wr_en_i && wr_idx_i == CTRL_IDX) ctrl_q <= wr_data_i;
      if (wr_en_i && wr_idx_i == SCR_IDX)  scr_q  <= wr_data_i;
      stat_q <= (stat_q & ~stat_clr) | stat_set;
    end
  end

  assign ctrl_o = ctrl_q;

  assert_reserved_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & ~STAT_MASK) == '0);
  assert_flag_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_set_i & STAT_MASK) != '0 |=>
      (stat_q & $past(flag_set_i & STAT_MASK)) == $past(flag_set_i & STAT_MASK));
  assert_ctrl_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == CTRL_IDX) |=> ctrl_q == $past(wr_data_i));
  assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == STAT_IDX && flag_set_i == '0) |=>
      stat_q == ($past(stat_q) & ~$past(wr_data_i) & STAT_MASK));
endmodule

// File: rtl/periph_io_space.sv
module periph_io_space
  import prs_pkg::*;
#(
  parameter int unsigned DM_AW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             io_we_i,
  input  logic [5:0]       io_addr_i,
  input  logic [7:0]       io_wdata_i,
  output logic [7:0]       io_rdata_o,
  input  logic [1:0]       bit_op_i,
  input  logic [5:0]       bit_addr_i,
  input  logic [2:0]       bit_sel_i,
  output logic             bit_val_o,
  output logic             illegal_o,
  input  logic             dm_we_i,
  input  logic [DM_AW-1:0] dm_addr_i,
  input  logic [7:0]       dm_wdata_i,
  output logic [7:0]       dm_rdata_o,
  output logic             dm_hit_o,
  input  logic [7:0]       flag_set_i,
  input  logic [7:0]       ext_in_i,
  output logic [7:0]       ctrl_o
);
  localparam int unsigned NRD = 3;
  localparam int unsigned P_IO = 0, P_BIT = 1, P_DM = 2;

  logic [AW-1:0]          dm_idx, wr_idx;
  logic                   dm_wr, bit_ok, bit_wr, wr_en;
  logic [DW-1:0]          bit_wdata, wr_data;
  logic [NRD-1:0][AW-1:0] rd_idx;
  logic [NRD-1:0][DW-1:0] rd_data;

  prs_addr_map #(.DM_AW(DM_AW)) u_map (
    .clk_i, .rst_ni,
    .dm_addr_i, .dm_we_i,
    .dm_hit_o, .dm_idx_o(dm_idx), .dm_wr_o(dm_wr),
    .bit_addr_i, .bit_ok_o(bit_ok)
  );

  prs_bit_rmw u_rmw (
    .clk_i, .rst_ni,
    .op_i(bit_op_i), .sel_i(bit_sel_i), .addr_ok_i(bit_ok),
    .rd_i(rd_data[P_BIT]),
    .wr_o(bit_wr), .wdata_o(bit_wdata), .val_o(bit_val_o), .illegal_o
  );

  // fixed priority: port write, then bit rmw, then data write
  always_comb begin
    wr_en   = io_we_i | bit_wr | dm_wr;
    wr_idx  = dm_idx;
    wr_data = dm_wdata_i;
    if (io_we_i) begin
      wr_idx  = io_addr_i;
      wr_data = io_wdata_i;
    end else if (bit_wr) begin
      wr_idx  = bit_addr_i;
      wr_data = bit_wdata;
    end
  end

  assign rd_idx[P_IO]  = io_addr_i;
  assign rd_idx[P_BIT] = bit_addr_i;
  assign rd_idx[P_DM]  = dm_idx;

  prs_regs #(.NRD(NRD)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .flag_set_i, .ext_in_i,
    .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .ctrl_o
  );

  assign io_rdata_o = rd_data[P_IO];
  assign dm_rdata_o = dm_hit_o ? rd_data[P_DM] : '0;

  assert_io_priority_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_we_i && io_addr_i == 6'h05) |=> ctrl_o == $past(io_wdata_i));
  assert_illegal_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o && !io_we_i && !dm_hit_o) |=> $stable(ctrl_o));
  assert_dm_miss_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dm_hit_o |-> dm_rdata_o == '0);
endmodule

// File: tb/tb_periph_io_space.sv
`timescale 1ns/1ps
module tb_periph_io_space;
  logic        clk = 0, rst_n = 0;
  logic        io_we = 0;
  logic [5:0]  io_addr = 0;
  logic [7:0]  io_wdata = 0;
  logic [7:0]  io_rdata;
  logic [1:0]  bit_op = 0;
  logic [5:0]  bit_addr = 0;
  logic [2:0]  bit_sel = 0;
  logic        bit_val, illegal;
  logic        dm_we = 0;
  logic [15:0] dm_addr = 0;
  logic [7:0]  dm_wdata = 0;
  logic [7:0]  dm_rdata;
  logic        dm_hit;
  logic [7:0]  flag_set = 0, ext_in = 0, ctrl;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  periph_io_space dut (
    .clk_i(clk), .rst_ni(rst_n),
    .io_we_i(io_we), .io_addr_i(io_addr), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .bit_op_i(bit_op), .bit_addr_i(bit_addr), .bit_sel_i(bit_sel),
    .bit_val_o(bit_val), .illegal_o(illegal),
    .dm_we_i(dm_we), .dm_addr_i(dm_addr), .dm_wdata_i(dm_wdata),
    .dm_rdata_o(dm_rdata), .dm_hit_o(dm_hit),
    .flag_set_i(flag_set), .ext_in_i(ext_in), .ctrl_o(ctrl)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    io_we = 0; bit_op = 0; dm_we = 0; flag_set = 0;
  endtask

  // drive for one cycle starting at negedge, leave idle at next negedge
  task automatic cyc();
    @(negedge clk); idle(); #1;
  endtask

  task automatic io_wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk); io_we = 1; io_addr = a; io_wdata = d;
    cyc();
  endtask

  task automatic io_rd(logic [5:0] a, output logic [7:0] d);
    io_addr = a; #1; d = io_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    io_rd(6'h05, v); chk("R13 ctrl", v, 8'h00);
    io_rd(6'h06, v); chk("R13 stat", v, 8'h00);
    io_rd(6'h2A, v); chk("R13 scratch", v, 8'h00);
    chk("R13 illegal", {7'b0, illegal}, 8'h00);
  endtask

  task automatic t_io_rw();
    logic [7:0] v;
    io_wr(6'h05, 8'hA5);
    io_rd(6'h05, v); chk("R3 ctrl port", v, 8'hA5);
    chk("R3 ctrl_o", ctrl, 8'hA5);
    io_wr(6'h10, 8'hFF);
    io_rd(6'h10, v); chk("R1 reserved read", v, 8'h00);
    io_wr(6'h2A, 8'h3C);
    io_rd(6'h2A, v); chk("R11 scratch port", v, 8'h3C);
  endtask

  task automatic t_dm();
    @(negedge clk); dm_addr = 16'h0025; #1;
    chk("R2 hit", {7'b0, dm_hit}, 8'h01);
    chk("R2 alias read", dm_rdata, 8'hA5);
    dm_we = 1; dm_wdata = 8'h5A; dm_addr = 16'h004A;
    cyc();
    chk("R11 scratch via dm", dm_rdata, 8'h5A);
    @(negedge clk); dm_we = 1; dm_wdata = 8'hFF; dm_addr = 16'h0005; #1;
    chk("R2 low miss", {7'b0, dm_hit}, 8'h00);
    chk("R2 miss rdata", dm_rdata, 8'h00);
    cyc();
    @(negedge clk); dm_we = 1; dm_wdata = 8'hFF; dm_addr = 16'h0125;
    cyc();
    @(negedge clk); dm_we = 1; dm_wdata = 8'hFF; dm_addr = 16'h0060;
    cyc();
    chk("R2 ctrl untouched", ctrl, 8'hA5);
    dm_addr = 16'h005F; #1;
    chk("R2 top edge hit", {7'b0, dm_hit}, 8'h01);
  endtask

  task automatic t_status();
    logic [7:0] v;
    @(negedge clk); flag_set = 8'hF5; cyc();
    io_rd(6'h06, v); chk("R4 set/reserved", v, 8'h05);
    io_wr(6'h06, 8'h01);
    io_rd(6'h06, v); chk("R4 w1c", v, 8'h04);
    io_wr(6'h06, 8'h00);
    io_rd(6'h06, v); chk("R4 w0 keeps", v, 8'h04);
    io_wr(6'h06, 8'h04);
    @(negedge clk); flag_set = 8'h01; io_we = 1; io_addr = 6'h06; io_wdata = 8'h01;
    cyc();
    io_rd(6'h06, v); chk("R5 set wins", v, 8'h01);
  endtask

  task automatic t_input();
    logic [7:0] v;
    ext_in = 8'h9E;
    io_rd(6'h07, v); chk("R6 live", v, 8'h9E);
    io_wr(6'h07, 8'h00);
    io_rd(6'h07, v); chk("R6 ro", v, 8'h9E);
    ext_in = 8'h21;
    io_rd(6'h07, v); chk("R6 follow", v, 8'h21);
  endtask

  task automatic bop(logic [1:0] op, logic [5:0] a, logic [2:0] s);
    @(negedge clk); bit_op = op; bit_addr = a; bit_sel = s;
    cyc();
  endtask

  task automatic t_bits();
    logic [7:0] v;
    io_wr(6'h05, 8'h00);
    bop(2'b01, 6'h05, 3'd6);
    chk("R7 set", ctrl, 8'h40);
    bop(2'b01, 6'h05, 3'd0);
    bop(2'b10, 6'h05, 3'd6);
    chk("R7 clear", ctrl, 8'h01);
    @(negedge clk); bit_op = 2'b11; bit_addr = 6'h05; bit_sel = 3'd0; #1;
    chk("R9 test 1", {7'b0, bit_val}, 8'h01);
    bit_sel = 3'd3; #1;
    chk("R9 test 0", {7'b0, bit_val}, 8'h00);
    cyc();
    chk("R9 no write", ctrl, 8'h01);
    // status rmw
    io_wr(6'h06, 8'hFF);
    @(negedge clk); flag_set = 8'h05; cyc();
    bop(2'b01, 6'h06, 3'd1);
    io_rd(6'h06, v); chk("R8 set clears read-1 flags", v, 8'h00);
    @(negedge clk); flag_set = 8'h0F; cyc();
    bop(2'b10, 6'h06, 3'd0);
    io_rd(6'h06, v); chk("R8 clear keeps target", v, 8'h01);
  endtask

  task automatic t_illegal();
    logic [7:0] v;
    io_wr(6'h2A, 8'h3C);
    @(negedge clk); bit_op = 2'b01; bit_addr = 6'h2A; bit_sel = 3'd0; #1;
    chk("R10 illegal flag", {7'b0, illegal}, 8'h01);
    cyc();
    io_rd(6'h2A, v); chk("R10 no change", v, 8'h3C);
    @(negedge clk); bit_op = 2'b11; bit_addr = 6'h2A; bit_sel = 3'd2; #1;
    chk("R10 test val zero", {7'b0, bit_val}, 8'h00);
    cyc();
    bit_addr = 6'h1F; bit_op = 2'b11; #1;
    chk("R10 edge legal", {7'b0, illegal}, 8'h00);
    bit_op = 2'b00;
  endtask

  task automatic t_priority();
    @(negedge clk);
    io_we = 1; io_addr = 6'h05; io_wdata = 8'h11;
    bit_op = 2'b01; bit_addr = 6'h05; bit_sel = 3'd7;
    dm_we = 1; dm_addr = 16'h0025; dm_wdata = 8'h22;
    cyc();
    chk("R12 port wins", ctrl, 8'h11);
    @(negedge clk);
    bit_op = 2'b01; bit_addr = 6'h05; bit_sel = 3'd7;
    dm_we = 1; dm_addr = 16'h0025; dm_wdata = 8'h22;
    cyc();
    chk("R12 bit over dm", ctrl, 8'h91);
    @(negedge clk); dm_we = 1; dm_addr = 16'h0025; dm_wdata = 8'h22;
    cyc();
    chk("R12 dm alone", ctrl, 8'h22);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_io_rw();
    t_dm();
    t_status();
    t_input();
    t_bits();
    t_illegal();
    t_priority();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule